// File: doc/BRIEF.md
# Single-Shot ADC Conversion Sequencer

This block sits between a host register bus and a multiplexed 12-bit analog-to-digital converter. The host programs a channel and a scale, enables the block, and sets a run bit. The block then latches the channel and scale and issues a one-cycle start pulse to the converter. It waits for the converter's done strobe, captures the sample and raises a done flag. The host polls that flag, or takes an interrupt, and then reads the sample.

The done flag has two views. The raw view always shows the flag. The masked view shows it only while the interrupt enable bit is set, and that view also drives the `irq` output. A write-one-to-clear register clears the flag. If the host clears the enable bit while a conversion is in flight, the conversion is abandoned and the flag is not set. A parameter picks where the scale field sits in the configuration register: a two-bit field at bits 10:9, or a single bit at bit 5.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every register reads 0 (control 0x00, configuration 0x04, data 0x4C, interrupt enable 0x50, clear 0x54, masked status 0x58, raw status 0x5C), and `irq` and `conv_start` are low.
- R2: A control write with bit 0 (enable) and bit 1 (run) both set, made while idle, drives `conv_start` high for exactly one cycle, starting the cycle after the write. During that cycle `conv_chan` and `conv_scale` carry the configured channel (configuration bits 4:0) and scale.
- R3: A control write with bit 1 set and bit 0 clear starts nothing: `conv_start` stays low and the busy bit reads 0.
- R4: When `conv_done` arrives during a conversion, `conv_data` is latched into data register bits 11:0 (upper bits read 0), raw status bit 0 becomes 1, and the busy bit returns to 0.
- R5: Writing 1 to bit 0 of the clear register (0x54) clears the done flag. Writing 0 there leaves it unchanged.
- R6: Masked status bit 0 and `irq` equal raw done AND interrupt-enable bit 0.
- R7: A control write that clears bit 0 during a conversion aborts it. Busy reads 0, a later `conv_done` is ignored, the done flag stays 0 and the data register keeps its previous value.
- R8: Configuration writes during a conversion do not change `conv_chan` or `conv_scale` until that conversion ends. Readback shows the new value.
- R9: Control readback returns enable at bit 0, busy at bit 1, 12-bit mode at bit 2 and the stored run count at bits 7:4. The run bit itself is not stored.
- R10: With `SCALE_NARROW`=0 the scale is configuration bits 10:9 (four scales). With `SCALE_NARROW`=1 it is bit 5 alone, and `conv_scale[1]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 5 | Channel held for the conversion |
| conv_scale | output | 2 | Scale held for the conversion |
| conv_done | input | 1 | Converter result strobe |
| conv_data | input | 12 | Converter result |
| irq | output | 1 | Masked done interrupt |

## Verification
The hardest case to reach is an abort: the enable bit has to fall after the start pulse and before the converter's done strobe arrives. The bench's converter model answers a fixed number of cycles after the start. The bench clears the enable bit on the write that follows the run write, so the strobe still arrives afterwards and has to be ignored. A second case uses the same window: the configuration register is rewritten mid-conversion while the held channel pins are watched. A full sweep of all 32 channels and all four scales runs through the default variant and the narrow variant side by side.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam logic [7:0] ADR_CTRL = 8'h00;
    localparam logic [7:0] ADR_CFG  = 8'h04;
    localparam logic [7:0] ADR_DATA = 8'h4C;
    localparam logic [7:0] ADR_IEN  = 8'h50;
    localparam logic [7:0] ADR_ICLR = 8'h54;
    localparam logic [7:0] ADR_MSTS = 8'h58;
    localparam logic [7:0] ADR_RSTS = 8'h5C;

    typedef enum logic {SEQ_IDLE, SEQ_WAIT} seq_state_e;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int BUS_W        = 32,
    parameter int CHAN_W       = 5,
    parameter int DATA_W       = 12,
    parameter bit SCALE_NARROW = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              busy,
    input  logic              raw_done,
    input  logic [DATA_W-1:0] result,
    output logic              en,
    output logic              ien,
    output logic              run_req,
    output logic              clr_done,
    output logic [CHAN_W-1:0] cfg_chan,
    output logic [1:0]        cfg_scale
);
    localparam int SCALE_W   = SCALE_NARROW ? 1 : 2;
    localparam int SCALE_LSB = SCALE_NARROW ? 5 : 9;

    typedef struct packed {
        logic              en;
        logic              mode12;
        logic [3:0]        runcnt;
        logic [CHAN_W-1:0] chan;
        logic [1:0]        scale;
        logic              ien;
    } regs_t;

    regs_t r_d, r_q;
    logic  unused_wbits;

    assign unused_wbits = ^bus_wdata;

    always_comb begin
        r_d      = r_q;
        run_req  = 1'b0;
        clr_done = 1'b0;
        if (bus_wr) begin
            case (bus_addr)
                ADR_CTRL: begin
                    r_d.en     = bus_wdata[0];
                    r_d.mode12 = bus_wdata[2];
                    r_d.runcnt = bus_wdata[7:4];
                    run_req    = bus_wdata[0] & bus_wdata[1] & ~busy;
                end
                ADR_CFG: begin
                    r_d.chan  = bus_wdata[CHAN_W-1:0];
                    r_d.scale = '0;
                    r_d.scale[SCALE_W-1:0] = bus_wdata[SCALE_LSB +: SCALE_W];
                end
                ADR_IEN:  r_d.ien = bus_wdata[0];
                ADR_ICLR: clr_done = bus_wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_CTRL: begin
                bus_rdata[0]   = r_q.en;
                bus_rdata[1]   = busy;
                bus_rdata[2]   = r_q.mode12;
                bus_rdata[7:4] = r_q.runcnt;
            end
            ADR_CFG: begin
                bus_rdata[CHAN_W-1:0]          = r_q.chan;
                bus_rdata[SCALE_LSB +: SCALE_W] = r_q.scale[SCALE_W-1:0];
            end
            ADR_DATA: bus_rdata[DATA_W-1:0] = result;
            ADR_IEN:  bus_rdata[0] = r_q.ien;
            ADR_MSTS: bus_rdata[0] = raw_done & r_q.ien;
            ADR_RSTS: bus_rdata[0] = raw_done;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign en        = r_q.en;
    assign ien       = r_q.ien;
    assign cfg_chan  = r_q.chan;
    assign cfg_scale = r_q.scale;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CHAN_W = 5,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              run_req,
    input  logic              clr_done,
    input  logic [CHAN_W-1:0] cfg_chan,
    input  logic [1:0]        cfg_scale,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic [1:0]        conv_scale,
    output logic              busy,
    output logic              raw_done,
    output logic [DATA_W-1:0] result
);
    typedef struct packed {
        seq_state_e        state;
        logic              start;
        logic [CHAN_W-1:0] chan;
        logic [1:0]        scale;
        logic [DATA_W-1:0] data;
        logic              raw;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        if (clr_done) s_d.raw = 1'b0;
        case (s_q.state)
            SEQ_IDLE: begin
                if (run_req) begin
                    s_d.state = SEQ_WAIT;
                    s_d.start = 1'b1;
                    s_d.chan  = cfg_chan;
                    s_d.scale = cfg_scale;
                end
            end
            SEQ_WAIT: begin
                if (!en) begin
                    s_d.state = SEQ_IDLE;
                end else if (conv_done && !s_q.start) begin
                    s_d.state = SEQ_IDLE;
                    s_d.data  = conv_data;
                    s_d.raw   = 1'b1;
                end
            end
            default: s_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign conv_start = s_q.start;
    assign conv_chan  = s_q.chan;
    assign conv_scale = s_q.scale;
    assign busy       = (s_q.state == SEQ_WAIT);
    assign raw_done   = s_q.raw;
    assign result     = s_q.data;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int BUS_W        = 32,
    parameter int CHAN_W       = 5,
    parameter int DATA_W       = 12,
    parameter bit SCALE_NARROW = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic [1:0]        conv_scale,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              irq
);
    logic              en, ien, run_req, clr_done, busy, raw_done;
    logic [CHAN_W-1:0] cfg_chan;
    logic [1:0]        cfg_scale;
    logic [DATA_W-1:0] result;

    adc_seq_regs #(
        .BUS_W(BUS_W), .CHAN_W(CHAN_W), .DATA_W(DATA_W), .SCALE_NARROW(SCALE_NARROW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .raw_done(raw_done), .result(result), .en(en), .ien(ien),
        .run_req(run_req), .clr_done(clr_done), .cfg_chan(cfg_chan),
        .cfg_scale(cfg_scale)
    );

    adc_seq_fsm #(.CHAN_W(CHAN_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .run_req(run_req),
        .clr_done(clr_done), .cfg_chan(cfg_chan), .cfg_scale(cfg_scale),
        .conv_done(conv_done), .conv_data(conv_data), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_scale(conv_scale), .busy(busy),
        .raw_done(raw_done), .result(result)
    );

    assign irq = raw_done & ien;
endmodule

// File: rtl/adc_seq_checks.sv
module adc_seq_checks #(
    parameter int CHAN_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_start,
    input logic [CHAN_W-1:0] conv_chan,
    input logic [1:0]        conv_scale,
    input logic              en,
    input logic              busy,
    input logic              raw_done,
    input logic              irq
);
    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_start_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> en);

    assert_abort_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !en) |=> (!busy && !$rose(raw_done)));

    assert_held_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_start) |-> ($stable(conv_chan) && $stable(conv_scale)));

    assert_irq_needs_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> raw_done);
endmodule

bind adc_seq_ctrl adc_seq_checks #(.CHAN_W(CHAN_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_scale(conv_scale), .en(en), .busy(busy), .raw_done(raw_done), .irq(irq)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic        start0, start1, irq0, irq1;
    logic [4:0]  chan0, chan1;
    logic [1:0]  scale0, scale1;
    logic        done_m = 1'b0;
    logic [11:0] data_m = '0;
    logic        pend_m = 1'b0;
    logic [2:0]  cnt_m = '0;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    adc_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata0), .conv_start(start0),
        .conv_chan(chan0), .conv_scale(scale0), .conv_done(done_m),
        .conv_data(data_m), .irq(irq0)
    );

    adc_seq_ctrl #(.SCALE_NARROW(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata1), .conv_start(start1),
        .conv_chan(chan1), .conv_scale(scale1), .conv_done(done_m),
        .conv_data(data_m), .irq(irq1)
    );

    function automatic logic [11:0] model_val(input int c, input int s);
        return 12'((c * 113 + s * 977 + 5) % 4096);
    endfunction

    // converter model: answers four cycles after the start pulse
    always @(posedge clk) begin
        done_m <= 1'b0;
        if (start0) begin
            pend_m <= 1'b1;
            cnt_m  <= 3'd3;
            data_m <= model_val(int'(chan0), int'(scale0));
        end else if (pend_m) begin
            if (cnt_m == 0) begin
                done_m <= 1'b1;
                pend_m <= 1'b0;
            end else begin
                cnt_m <= cnt_m - 3'd1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v0, output logic [31:0] v1);
        bus_addr = a;
        #1;
        v0 = rdata0;
        v1 = rdata1;
    endtask

    task automatic poll_done(input string tag);
        logic [31:0] v0, v1;
        bit seen = 0;
        for (int i = 0; i < 40 && !seen; i++) begin
            @(negedge clk);
            rd(8'h5C, v0, v1);
            seen = v0[0];
        end
        chk(seen, tag, 0, 1);
    endtask

    function automatic logic [31:0] cfg_word(input int c, input int s);
        return 32'(c) | (32'(s) << 9) | (32'(s & 1) << 5);
    endfunction

    task automatic convert(input int c, input int s);
        logic [31:0] v0, v1;
        wr(8'h00, 32'h1);
        wr(8'h54, 32'h1);
        wr(8'h04, cfg_word(c, s));
        wr(8'h00, 32'h5);
        wr(8'h00, 32'h7);
        // R2: start pulse with held selection, the cycle after the write
        chk(start0 == 1'b1 && chan0 == 5'(c) && scale0 == 2'(s), "R2 start/select",
            {start0, chan0, scale0}, {1'b1, 5'(c), 2'(s)});
        // R10: narrow variant sees only bit 5
        chk(start1 == 1'b1 && scale1 == 2'(s & 1), "R10 narrow scale", scale1, s & 1);
        rd(8'h00, v0, v1);
        chk(v0[1] == 1'b1, "R9 busy bit", v0[1], 1);
        poll_done("R4 done seen");
        rd(8'h4C, v0, v1);
        chk(v0 == 32'(model_val(c, s)) && v1 == v0, "R4 data", v0, model_val(c, s));
        rd(8'h00, v0, v1);
        chk(v0[1] == 1'b0, "R4 busy cleared", v0[1], 0);
        wr(8'h00, 32'h0);
    endtask

    initial begin
        logic [31:0] v0, v1;
        logic [11:0] prev;
        logic [7:0]  adr [7];
        adr = '{8'h00, 8'h04, 8'h4C, 8'h50, 8'h54, 8'h58, 8'h5C};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int i = 0; i < 7; i++) begin
            rd(adr[i], v0, v1);
            chk(v0 == 0 && v1 == 0, "R1 reset reg", v0, 0);
        end
        chk(irq0 == 0 && start0 == 0, "R1 reset pins", {irq0, start0}, 0);

        // sweep every channel and scale (R2, R4, R10)
        for (int c = 0; c < 32; c++)
            for (int s = 0; s < 4; s++)
                convert(c, s);

        // R10: configuration readback per variant
        wr(8'h04, cfg_word(19, 3));
        rd(8'h04, v0, v1);
        chk(v0 == 32'(19 | (3 << 9)), "R10 wide readback", v0, 19 | (3 << 9));
        chk(v1 == 32'(19 | (1 << 5)), "R10 narrow readback", v1, 19 | (1 << 5));

        // R9: control field readback
        wr(8'h00, 32'hA5);
        rd(8'h00, v0, v1);
        chk(v0 == 32'hA5, "R9 ctrl readback", v0, 32'hA5);
        wr(8'h00, 32'h0);

        // R5, R6: flag clear and mask
        convert(3, 1);
        wr(8'h50, 32'h0);
        rd(8'h58, v0, v1);
        chk(v0 == 0 && irq0 == 0, "R6 masked off", {v0[0], irq0}, 0);
        wr(8'h50, 32'h1);
        rd(8'h58, v0, v1);
        chk(v0 == 1 && irq0 == 1, "R6 masked on", {v0[0], irq0}, 3);
        wr(8'h54, 32'h0);
        rd(8'h5C, v0, v1);
        chk(v0 == 1, "R5 write zero keeps flag", v0, 1);
        wr(8'h54, 32'h1);
        rd(8'h5C, v0, v1);
        chk(v0 == 0 && irq0 == 0, "R5 clear", {v0[0], irq0}, 0);
        wr(8'h50, 32'h0);

        // R3: run without enable
        wr(8'h04, cfg_word(9, 2));
        wr(8'h00, 32'h2);
        begin
            bit any = 0;
            for (int i = 0; i < 8; i++) begin
                any |= start0;
                @(negedge clk);
            end
            chk(!any, "R3 no start", any, 0);
        end
        rd(8'h00, v0, v1);
        chk(v0 == 0, "R3 ctrl idle", v0, 0);

        // R7: abort mid-conversion
        rd(8'h4C, v0, v1);
        prev = v0[11:0];
        wr(8'h00, 32'h1);
        wr(8'h54, 32'h1);
        wr(8'h04, cfg_word(22, 1));
        wr(8'h00, 32'h7);
        wr(8'h00, 32'h0);
        repeat (12) @(negedge clk);
        rd(8'h5C, v0, v1);
        chk(v0 == 0, "R7 no done after abort", v0, 0);
        rd(8'h00, v0, v1);
        chk(v0[1] == 0, "R7 busy cleared", v0[1], 0);
        rd(8'h4C, v0, v1);
        chk(v0[11:0] == prev, "R7 data kept", v0, prev);

        // R8: configuration write during conversion
        wr(8'h00, 32'h1);
        wr(8'h54, 32'h1);
        wr(8'h04, cfg_word(7, 2));
        wr(8'h00, 32'h7);
        wr(8'h04, cfg_word(20, 1));
        chk(chan0 == 5'd7 && scale0 == 2'd2, "R8 held select", {chan0, scale0}, {5'd7, 2'd2});
        rd(8'h04, v0, v1);
        chk(v0 == 32'(20 | (1 << 9)), "R8 readback new", v0, 20 | (1 << 9));
        poll_done("R8 done");
        chk(chan0 == 5'd7, "R8 held to end", chan0, 7);
        rd(8'h4C, v0, v1);
        chk(v0 == 32'(model_val(7, 2)), "R8 data", v0, model_val(7, 2));
        wr(8'h00, 32'h0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule